// File: doc/BRIEF.md
# Dual-Port Video Memory

This block models a video memory with two independent ways in. A slow random port behaves like an ordinary DRAM: the row and column address share one multiplexed bus, the row is taken when the row strobe falls, and the column is taken when the column strobe falls. Bytes are read and written one at a time through this port. A fast serial port sits beside it and holds one whole row of the array in a shift register. A display refresh engine reads the screen through the serial port. The processor updates the image through the random port.

A transfer cycle is a random-port cycle with the transfer strobe held low at the row strobe's fall. When the column strobe falls, the selected row is copied into the shift register in one step, and the column address becomes the first serial position. After that, each rising edge of the serial clock moves the serial output to the next column, and the position wraps at the end of the row. The random port is free again as soon as the transfer ends. Reads and writes can then run while the serial stream continues, and they do not touch the bytes already in the shift register.

The strobes, serial clock and enables are active-low, except the serial clock. All of them are sampled on the block clock. Edges are found by comparing each input with its value from the previous clock. Every event takes effect at the clock edge that first sees the new level. The size is set by `AW`: the array has 2^AW rows and 2^AW columns of `DW`-bit words, so `AW`=9 gives the full 512 x 512 x 8 organisation.

Top module: `vram_dual_port`

## Requirements
- R1: After reset, `dout_en` and `sdata_en` are low, and `dout` and `sdata` are all zeros while `oe_n` and `sen_n` are high.
- R2: A fall of `ras_n` latches `addr` as the row. A later fall of `cas_n`, with `ras_n` still low and `we_n` low, writes `din` to that row at column `addr`. A write cycle never drives `dout_en`.
- R3: A fall of `cas_n` with `ras_n` low and `we_n` high captures the addressed byte. That byte appears on `dout`, with `dout_en` high, while `oe_n`, `ras_n` and `cas_n` are all low. At all other times `dout` is zero and `dout_en` is low.
- R4: If `xfer_n` is low when `ras_n` falls, the cycle is a transfer. The `cas_n` fall then copies every byte of the row into the shift register and sets the serial position to the column on `addr`. The transfer leaves the array unchanged.
- R5: `sdata` shows the shift-register byte at the serial position. Each rising edge of `sclk` moves the position up by one column, so the bytes come out in the order D[x], D[x+1], D[x+2] and so on.
- R6: The serial position wraps from the last column (2^AW-1) to column 0.
- R7: `sdata` is driven and `sdata_en` is high only while `sen_n` is low. Otherwise `sdata` is zero. The position still advances on `sclk` while the output is disabled.
- R8: Random reads and writes after a transfer, including writes to the transferred row, do not change the bytes the serial port delivers.
- R9: A fall of `cas_n` while `ras_n` is high does nothing. In particular, no write takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write select for random cycles, active low |
| oe_n | input | 1 | Random read output enable, active low |
| xfer_n | input | 1 | Marks a row-to-register transfer when low at the row strobe's fall |
| addr | input | AW | Multiplexed row/column address |
| din | input | DW | Random write data |
| dout | output | DW | Random read data, zero when not driven |
| dout_en | output | 1 | High while `dout` carries read data |
| sclk | input | 1 | Serial clock; each rising edge advances one column |
| sen_n | input | 1 | Serial output enable, active low |
| sdata | output | DW | Serial data, zero when not driven |
| sdata_en | output | 1 | High while `sdata` is driven |

## Verification
The bench builds the block with `AW`=4 and `DW`=8, so the array is 16 x 16. With this size the whole array can be written in a few thousand cycles, which gives every byte a known value. A serial stream also crosses the wrap point after only a few clock pulses. The run mixes random reads, writes, transfers, serial pulses and enable toggles. Because of this, writes to a row that was just transferred and transfers that land near the last column come up many times. The directed cases cover a wrap starting from column 13, serial pulses while the output is disabled, and a column strobe fall with the row strobe high.

// File: rtl/vram_pkg.sv
package vram_pkg;

  // Kind of random-port cycle, decoded at the column strobe fall.
  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_READ  = 2'd1,
    EV_WRITE = 2'd2,
    EV_XFER  = 2'd3
  } vram_ev_e;

endpackage

// File: rtl/vram_strobe_ctl.sv
module vram_strobe_ctl
  import vram_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ras_n,
  input  logic          cas_n,
  input  logic          we_n,
  input  logic          xfer_n,
  input  logic [AW-1:0] addr,
  output logic [AW-1:0] row_q,
  output vram_ev_e      ev,
  output logic          rd_open
);

  logic          ras_q, ras_d;
  logic          cas_q, cas_d;
  logic          xfer_q, xfer_d;
  logic [AW-1:0] row_d;
  logic          rd_open_d;
  logic          ras_fall, cas_fall;

  // Row fall needs the previous sample high. A column fall only counts
  // when the row strobe was already low on the previous sample, so the
  // row latch has settled before the column strobe acts.
  assign ras_fall = ras_q & ~ras_n;
  assign cas_fall = cas_q & ~cas_n & ~ras_q & ~ras_n;

  always_comb begin
    ev = EV_NONE;
    if (cas_fall) begin
      if (xfer_q)     ev = EV_XFER;
      else if (we_n)  ev = EV_READ;
      else            ev = EV_WRITE;
    end
  end

  always_comb begin
    ras_d     = ras_n;
    cas_d     = cas_n;
    row_d     = row_q;
    xfer_d    = xfer_q;
    rd_open_d = rd_open;
    if (ras_fall) begin
      row_d  = addr;
      xfer_d = ~xfer_n;
    end
    if (ev == EV_READ)        rd_open_d = 1'b1;
    else if (cas_n || ras_n)  rd_open_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q   <= 1'b1;
      cas_q   <= 1'b1;
      row_q   <= '0;
      xfer_q  <= 1'b0;
      rd_open <= 1'b0;
    end else begin
      ras_q   <= ras_d;
      cas_q   <= cas_d;
      row_q   <= row_d;
      xfer_q  <= xfer_d;
      rd_open <= rd_open_d;
    end
  end

  AST_ONE_EVENT_PER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != EV_NONE) |=> (ev == EV_NONE)); // R2

  AST_NO_EVENT_WITHOUT_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    ras_n |-> (ev == EV_NONE)); // R9

endmodule

// File: rtl/vram_array.sv
module vram_array #(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [AW-1:0]          row,
  input  logic [AW-1:0]          col,
  input  logic [DW-1:0]          wdata,
  output logic [DW-1:0]          rd_byte,
  output logic [(1<<AW)*DW-1:0]  row_bits
);

  localparam int ROWS = 1 << AW;
  localparam int COLS = 1 << AW;
  localparam int RW   = COLS * DW;

  logic [RW-1:0] mem [ROWS];
  logic [DW-1:0] rd_byte_d;
  logic [RW-1:0] cur_row;

  assign cur_row  = mem[row];
  assign row_bits = cur_row;

  // Storage carries no reset.
  always_ff @(posedge clk) begin
    if (wr_en) mem[row][DW*int'(col) +: DW] <= wdata;
  end

  always_comb begin
    rd_byte_d = rd_byte;
    if (rd_en) rd_byte_d = cur_row[DW*int'(col) +: DW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_byte <= '0;
    else        rd_byte <= rd_byte_d;
  end

  AST_ROW_KEPT_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!wr_en) && $stable(row)) |-> $stable(row_bits)); // R4

endmodule

// File: rtl/vram_serial.sv
module vram_serial #(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [(1<<AW)*DW-1:0]  load_row,
  input  logic [AW-1:0]          load_col,
  input  logic                   sclk,
  input  logic                   sen_n,
  output logic [DW-1:0]          sdata,
  output logic                   sdata_en
);

  localparam int COLS = 1 << AW;
  localparam int RW   = COLS * DW;

  logic [RW-1:0] sreg, sreg_d;
  logic [AW-1:0] ptr, ptr_d;
  logic          sc_q;
  logic          sc_rise;

  assign sc_rise = sclk & ~sc_q;

  // A transfer in the same cycle as a serial clock edge takes priority.
  always_comb begin
    sreg_d = sreg;
    ptr_d  = ptr;
    if (load) begin
      sreg_d = load_row;
      ptr_d  = load_col;
    end else if (sc_rise) begin
      ptr_d  = ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0;
      ptr  <= '0;
      sc_q <= 1'b0;
    end else begin
      sreg <= sreg_d;
      ptr  <= ptr_d;
      sc_q <= sclk;
    end
  end

  assign sdata_en = ~sen_n;
  assign sdata    = sen_n ? '0 : sreg[DW*int'(ptr) +: DW];

  AST_SREG_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(sreg)); // R8

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_rise && !load) |=> (ptr == AW'($past(ptr) + 1'b1))); // R5

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_rise && !load && (ptr == '1)) |=> (ptr == '0)); // R6

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sc_rise && !load) |=> $stable(ptr)); // R5

endmodule

// File: rtl/vram_dual_port.sv
module vram_dual_port
  import vram_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ras_n,
  input  logic          cas_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic          xfer_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_en,
  input  logic          sclk,
  input  logic          sen_n,
  output logic [DW-1:0] sdata,
  output logic          sdata_en
);

  localparam int RW = (1 << AW) * DW;

  logic [AW-1:0] row_q;
  vram_ev_e      ev;
  logic          rd_open;
  logic [DW-1:0] rd_byte;
  logic [RW-1:0] row_bits;

  vram_strobe_ctl #(.AW(AW)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .we_n    (we_n),
    .xfer_n  (xfer_n),
    .addr    (addr),
    .row_q   (row_q),
    .ev      (ev),
    .rd_open (rd_open)
  );

  vram_array #(.AW(AW), .DW(DW)) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ev == EV_WRITE),
    .rd_en    (ev == EV_READ),
    .row      (row_q),
    .col      (addr),
    .wdata    (din),
    .rd_byte  (rd_byte),
    .row_bits (row_bits)
  );

  vram_serial #(.AW(AW), .DW(DW)) u_serial (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ev == EV_XFER),
    .load_row (row_bits),
    .load_col (addr),
    .sclk     (sclk),
    .sen_n    (sen_n),
    .sdata    (sdata),
    .sdata_en (sdata_en)
  );

  // Random read data is driven only inside an open read cycle.
  assign dout_en = rd_open & ~oe_n & ~cas_n & ~ras_n;
  assign dout    = dout_en ? rd_byte : '0;

  AST_WRITE_NEVER_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_WRITE) |=> !dout_en); // R2

  AST_SERIAL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    sen_n |-> (!sdata_en && (sdata == '0))); // R7

  AST_DOUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> (dout == '0)); // R3

endmodule

// File: tb/vram_dual_port_test.sv
module vram_dual_port_test;

  localparam int AW = 4;
  localparam int DW = 8;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ras_n, cas_n, we_n, oe_n, xfer_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;
  logic          dout_en;
  logic          sclk, sen_n;
  logic [DW-1:0] sdata;
  logic          sdata_en;

  always #5 clk = ~clk;

  vram_dual_port #(.AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .xfer_n(xfer_n), .addr(addr), .din(din), .dout(dout),
    .dout_en(dout_en), .sclk(sclk), .sen_n(sen_n), .sdata(sdata),
    .sdata_en(sdata_en)
  );

  logic [DW-1:0] model [N][N];
  logic [DW-1:0] shm [N];
  int            sp;
  int            checks = 0;
  int            errors = 0;
  bit            done = 1'b0;

  function automatic logic [DW-1:0] fill_val(int r, int c);
    return DW'((r * 16 + c) ^ 8'h5a);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Serial output check against the bench's shift-register model.
  task automatic scheck(input string req);
    #1;
    if (!sen_n) chk(sdata_en === 1'b1 && sdata === shm[sp], req, int'(sdata), int'(shm[sp]));
    else        chk(sdata_en === 1'b0 && sdata === '0, "R7", int'(sdata), 0);
  endtask

  // kind: 0 read, 1 write, 2 transfer
  task automatic rcycle(input int kind, input int row, input int col,
                        input logic [DW-1:0] d, input string req);
    step(); addr = AW'(row); xfer_n = (kind != 2); ras_n = 1'b0;
    step(); addr = AW'(col); we_n = (kind != 1); din = d;
    step(); cas_n = 1'b0;
    step();
    if (kind == 1) model[row][col] = d;
    if (kind == 2) begin
      for (int c = 0; c < N; c++) shm[c] = model[row][c];
      sp = col;
    end
    if (kind == 0) begin
      #1;
      chk(dout_en === 1'b0 && dout === '0, "R3", int'(dout), 0);
      oe_n = 1'b0;
      #1;
      chk(dout_en === 1'b1 && dout === model[row][col], req,
          int'(dout), int'(model[row][col]));
    end
    if (kind == 1) begin
      #1;
      chk(dout_en === 1'b0, "R2", int'(dout_en), 0);
    end
    step(); oe_n = 1'b1; cas_n = 1'b1; ras_n = 1'b1; we_n = 1'b1; xfer_n = 1'b1;
    #1;
    chk(dout_en === 1'b0 && dout === '0, "R3", int'(dout), 0);
  endtask

  task automatic spulse(input string req);
    step(); sclk = 1'b1;
    step(); sclk = 1'b0;
    sp = (sp + 1) % N;
    scheck(req);
  endtask

  initial begin
    void'($urandom(32'h00c0ffee));
    rst_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    xfer_n = 1'b1; addr = '0; din = '0; sclk = 1'b0; sen_n = 1'b1; sp = 0;
    for (int c = 0; c < N; c++) shm[c] = '0;
    repeat (3) step();
    #1;
    chk(dout_en === 1'b0 && dout === '0, "R1", int'(dout), 0);
    chk(sdata_en === 1'b0 && sdata === '0, "R1", int'(sdata), 0);
    step(); rst_n = 1'b1;
    step();

    // R2: fill the whole array with known bytes
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++)
        rcycle(1, r, c, fill_val(r, c), "R2");
    rcycle(0, 0, 0, 8'h00, "R2");
    rcycle(0, N-1, N-1, 8'h00, "R2");
    rcycle(0, 7, 3, 8'h00, "R3");

    // R4 and R6: transfer near the row end, then stream across the wrap
    rcycle(2, 3, 13, 8'h00, "R4");
    step(); sen_n = 1'b0;
    scheck("R4");
    spulse("R5");
    spulse("R5");
    spulse("R6");
    spulse("R6");
    rcycle(0, 3, 5, 8'h00, "R4");

    // R8: overwrite a transferred byte, the stream keeps the old one
    rcycle(1, 3, 2, 8'ha5, "R8");
    spulse("R8");
    rcycle(0, 3, 2, 8'h00, "R8");

    // R7: disabled output, pointer still advances
    step(); sen_n = 1'b1;
    scheck("R7");
    spulse("R7");
    spulse("R7");
    step(); sen_n = 1'b0;
    scheck("R7");

    // R9: column strobe fall with the row strobe high
    step(); addr = AW'(4); din = 8'hee; we_n = 1'b0;
    step(); cas_n = 1'b0;
    step();
    step(); cas_n = 1'b1; we_n = 1'b1;
    rcycle(0, 0, 4, 8'h00, "R9");
    rcycle(0, 3, 4, 8'h00, "R9");

    // Mixed random traffic
    for (int i = 0; i < 400; i++) begin
      int op;
      int r;
      int c;
      op = int'($urandom % 6);
      r  = int'($urandom % N);
      c  = int'($urandom % N);
      case (op)
        0: rcycle(0, r, c, 8'h00, "R3");
        1: rcycle(1, r, c, DW'($urandom), "R2");
        2: rcycle(2, r, c, 8'h00, "R4");
        3: spulse((sp == N-1) ? "R6" : "R5");
        4: begin step(); sen_n = ~sen_n; end
        default: rcycle(1, r, c, DW'($urandom), "R8");
      endcase
      scheck("R8");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule